// File: doc/BRIEF.md
# Parity-Checked Fully Associative Translation Buffer

This block is a small, fully associative translation buffer. Each slot holds a virtual page tag, a physical data word, a valid bit and a lock bit. It also holds one even-parity bit over the tag and a second over the data. A lookup presents a virtual page number and gets, in the same cycle, exactly one of three answers: a hit that carries the physical data, a miss, or a precise access error.

Parity is generated when a slot is written. Two write inputs can invert either stored parity bit, so that corrupted slots can be produced on purpose. A slot whose tag parity is broken never takes part in matching. Data parity is examined only on the slot that a lookup selects. A data error there turns the hit into an access error, and the fault status register captures the slot index.

Software has three further controls:
- A diagnostic port reads the tag or the data of any slot by index. A read that meets bad parity invalidates that slot and raises a separate urgent flag.
- A demap port clears a slot's valid bit.
- A two-bit write-one-to-clear strobe empties either status register.

Top module: `parity_xlat_buf`

## Requirements
- R1: A write stores the tag, data and lock bit, sets valid, and stores even parity for each field. Parity is inverted when the matching flip input is 1. A later lookup of that tag hits, returning the data and the slot index.
- R2: A slot whose stored tag parity is wrong never matches any lookup address.
- R3: A locked slot with a tag parity error makes a lookup of its own tag return a miss.
- R4: Data parity is examined only on the selected matching slot. Bad data parity in slots that do not match has no effect on the outcome or on the fault status.
- R5: Lookup outputs are combinational in the request cycle. With the lookup enable high, exactly one of hit, miss and error is 1. An error has priority over a hit, forces the returned data to zero and reports the slot index. With the enable low, all three are 0.
- R6: On an error, the fault status valid bit and the fault index are set at the next clock edge. Both hold until bit 0 of the clear strobe is 1. A new error in the same cycle as a clear wins.
- R7: A diagnostic read returns the data field (select = 1) or the zero-extended tag field (select = 0), along with the slot's valid and lock bits. If the read field has a parity error, the slot is invalidated at the next edge and the urgent flag and urgent index are set. These hold until bit 1 of the clear strobe is 1.
- R8: When several valid slots match with good tag parity, the lowest index is selected. That slot's data parity alone decides between hit and error.
- R9: A demap clears the valid bit of the indexed slot whatever its lock bit, and the lock bit is kept. Invalid slots never match.
- R10: After reset, every slot is invalid and both status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write a slot |
| wrIdx | input | IDX_W | Slot to write |
| wrTag | input | TAG_W | Tag to store |
| wrData | input | DATA_W | Data to store |
| wrLock | input | 1 | Lock bit to store |
| wrFlipTagPar | input | 1 | Invert the generated tag parity |
| wrFlipDataPar | input | 1 | Invert the generated data parity |
| lkEn | input | 1 | Lookup request |
| lkVpn | input | TAG_W | Virtual page number to look up |
| lkHit | output | 1 | Lookup hit |
| lkMiss | output | 1 | Lookup miss |
| lkErr | output | 1 | Precise access error |
| lkIdx | output | IDX_W | Selected slot on hit or error, else 0 |
| lkData | output | DATA_W | Physical data on hit, else 0 |
| diagEn | input | 1 | Diagnostic read request |
| diagIdx | input | IDX_W | Slot to read |
| diagSelData | input | 1 | 1 reads data, 0 reads tag |
| diagRdData | output | RD_W | Field read, zero-extended |
| diagRdValid | output | 1 | Valid bit of the read slot |
| diagRdLock | output | 1 | Lock bit of the read slot |
| demapEn | input | 1 | Invalidate a slot |
| demapIdx | input | IDX_W | Slot to invalidate |
| statusClr | input | 2 | Bit 0 clears fault status, bit 1 clears urgent status |
| faultValid | output | 1 | Lookup parity error recorded |
| faultIdx | output | IDX_W | Slot of the recorded lookup error |
| urgErr | output | 1 | Diagnostic-read parity error recorded |
| urgIdx | output | IDX_W | Slot of the recorded diagnostic error |

## Verification
The bench keeps the full 16-slot depth, so both index 0 and index 15 can be selected and priority can be shown between non-adjacent slots. It narrows the tag to 10 bits and the data to 14 bits. The narrow tag makes the zero-extension on the diagnostic port visible, and it keeps the directed patterns short. With these widths, locked and unlocked slots with injected tag or data faults can sit beside healthy slots that share their tag. That lets one run cover suppressed matches, lowest-index selection of a corrupt slot, and contention between an error and a clear strobe.

// File: rtl/pxb_pkg.sv
`timescale 1ns/1ps
package pxb_pkg;
  // Strobes from control to datapath; indices travel on the top ports.
  typedef struct packed {
    logic demapKill;
    logic diagKill;
  } pxbStrobe_t;
endpackage

// File: rtl/pxb_datapath.sv
`timescale 1ns/1ps
module pxb_datapath
  import pxb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int TAG_W       = 20,
  parameter int DATA_W      = 24,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int RD_W       = (TAG_W > DATA_W) ? TAG_W : DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLock,
  input  logic              wrFlipTagPar,
  input  logic              wrFlipDataPar,
  input  logic [TAG_W-1:0]  lkVpn,
  input  logic [IDX_W-1:0]  diagIdx,
  input  logic              diagSelData,
  input  logic [IDX_W-1:0]  demapIdx,
  input  pxbStrobe_t        strobe,
  output logic              dpFound,
  output logic [IDX_W-1:0]  dpIdx,
  output logic              dpDataBad,
  output logic [DATA_W-1:0] dpData,
  output logic              dpDiagBad,
  output logic [RD_W-1:0]   diagRdData,
  output logic              diagRdValid,
  output logic              diagRdLock
);
  logic [TAG_W-1:0]  tagArr  [NUM_ENTRIES];
  logic [DATA_W-1:0] dataArr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validArr, lockArr, tagParArr, dataParArr;
  logic [NUM_ENTRIES-1:0] tagBadVec, dataBadVec, matchVec;

  // Storage: a write sets valid; either kill strobe clears it and wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr   <= '0;
      lockArr    <= '0;
      tagParArr  <= '0;
      dataParArr <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
      end
    end else begin
      if (wrEn) begin
        tagArr[wrIdx]     <= wrTag;
        dataArr[wrIdx]    <= wrData;
        lockArr[wrIdx]    <= wrLock;
        tagParArr[wrIdx]  <= (^wrTag) ^ wrFlipTagPar;
        dataParArr[wrIdx] <= (^wrData) ^ wrFlipDataPar;
        validArr[wrIdx]   <= 1'b1;
      end
      if (strobe.demapKill) validArr[demapIdx] <= 1'b0;
      if (strobe.diagKill)  validArr[diagIdx]  <= 1'b0;
    end
  end

  // Per-slot checkers and comparators.
  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_slot
    assign tagBadVec[gi]  = ^{tagArr[gi], tagParArr[gi]};
    assign dataBadVec[gi] = ^{dataArr[gi], dataParArr[gi]};
    assign matchVec[gi]   = validArr[gi] && !tagBadVec[gi] && (tagArr[gi] == lkVpn);
  end

  // Lowest matching index wins.
  always_comb begin
    dpFound = 1'b0;
    dpIdx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        dpFound = 1'b1;
        dpIdx   = IDX_W'(i);
      end
    end
  end

  assign dpDataBad   = dpFound && dataBadVec[dpIdx];
  assign dpData      = (dpFound && !dpDataBad) ? dataArr[dpIdx] : '0;
  assign dpDiagBad   = diagSelData ? dataBadVec[diagIdx] : tagBadVec[diagIdx];
  assign diagRdData  = diagSelData ? RD_W'(dataArr[diagIdx]) : RD_W'(tagArr[diagIdx]);
  assign diagRdValid = validArr[diagIdx];
  assign diagRdLock  = lockArr[diagIdx];

  // R2: a selected slot is valid with an intact tag.
  p_sel_tag_sound_r2: assert property (@(posedge clk) disable iff (!rstN)
    dpFound |-> (validArr[dpIdx] && !tagBadVec[dpIdx] && tagArr[dpIdx] == lkVpn));
  // R8: no lower-indexed slot matches.
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    dpFound |-> ((matchVec & ((NUM_ENTRIES'(1) << dpIdx) - NUM_ENTRIES'(1))) == '0));
  // R9: a demapped slot is invalid next cycle.
  p_demap_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.demapKill |=> !validArr[$past(demapIdx)]);
  // R7: a diagnostic kill invalidates the read slot.
  p_diag_kill_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.diagKill |=> !validArr[$past(diagIdx)]);
endmodule

// File: rtl/pxb_control.sv
`timescale 1ns/1ps
module pxb_control
  import pxb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkEn,
  input  logic             diagEn,
  input  logic [IDX_W-1:0] diagIdx,
  input  logic             demapEn,
  input  logic [1:0]       statusClr,
  input  logic             dpFound,
  input  logic [IDX_W-1:0] dpIdx,
  input  logic             dpDataBad,
  input  logic             dpDiagBad,
  output logic             lkHit,
  output logic             lkMiss,
  output logic             lkErr,
  output logic [IDX_W-1:0] lkIdx,
  output pxbStrobe_t       strobe,
  output logic             faultValid,
  output logic [IDX_W-1:0] faultIdx,
  output logic             urgErr,
  output logic [IDX_W-1:0] urgIdx
);
  assign lkHit  = lkEn && dpFound && !dpDataBad;
  assign lkErr  = lkEn && dpFound && dpDataBad;
  assign lkMiss = lkEn && !dpFound;
  assign lkIdx  = (lkEn && dpFound) ? dpIdx : '0;

  assign strobe.demapKill = demapEn;
  assign strobe.diagKill  = diagEn && dpDiagBad;

  // Fault status: capture beats clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultValid <= 1'b0;
      faultIdx   <= '0;
    end else if (lkErr) begin
      faultValid <= 1'b1;
      faultIdx   <= dpIdx;
    end else if (statusClr[0]) begin
      faultValid <= 1'b0;
      faultIdx   <= '0;
    end
  end

  // Urgent status from diagnostic reads.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      urgErr <= 1'b0;
      urgIdx <= '0;
    end else if (strobe.diagKill) begin
      urgErr <= 1'b1;
      urgIdx <= diagIdx;
    end else if (statusClr[1]) begin
      urgErr <= 1'b0;
      urgIdx <= '0;
    end
  end

  // R5: one answer per request, none when idle.
  p_one_answer_r5: assert property (@(posedge clk) disable iff (!rstN)
    lkEn |-> $onehot({lkHit, lkMiss, lkErr}));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !lkEn |-> !(lkHit || lkMiss || lkErr));
  // R6: error is captured with its index.
  p_fault_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    lkErr |=> (faultValid && faultIdx == $past(lkIdx)));
  // R6: status holds without a clear or new error.
  p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !lkErr && !statusClr[0]) |=> (faultValid && $stable(faultIdx)));
  // R7: urgent flag follows a diagnostic kill.
  p_urgent_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.diagKill |=> (urgErr && urgIdx == $past(diagIdx)));
endmodule

// File: rtl/parity_xlat_buf.sv
`timescale 1ns/1ps
module parity_xlat_buf
  import pxb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int TAG_W       = 20,
  parameter int DATA_W      = 24,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int RD_W       = (TAG_W > DATA_W) ? TAG_W : DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLock,
  input  logic              wrFlipTagPar,
  input  logic              wrFlipDataPar,
  input  logic              lkEn,
  input  logic [TAG_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkErr,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [DATA_W-1:0] lkData,
  input  logic              diagEn,
  input  logic [IDX_W-1:0]  diagIdx,
  input  logic              diagSelData,
  output logic [RD_W-1:0]   diagRdData,
  output logic              diagRdValid,
  output logic              diagRdLock,
  input  logic              demapEn,
  input  logic [IDX_W-1:0]  demapIdx,
  input  logic [1:0]        statusClr,
  output logic              faultValid,
  output logic [IDX_W-1:0]  faultIdx,
  output logic              urgErr,
  output logic [IDX_W-1:0]  urgIdx
);
  pxbStrobe_t        strobe;
  logic              dpFound, dpDataBad, dpDiagBad;
  logic [IDX_W-1:0]  dpIdx;
  logic [DATA_W-1:0] dpData;

  pxb_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag), .wrData(wrData), .wrLock(wrLock),
    .wrFlipTagPar(wrFlipTagPar), .wrFlipDataPar(wrFlipDataPar),
    .lkVpn(lkVpn), .diagIdx(diagIdx), .diagSelData(diagSelData), .demapIdx(demapIdx),
    .strobe(strobe),
    .dpFound(dpFound), .dpIdx(dpIdx), .dpDataBad(dpDataBad), .dpData(dpData),
    .dpDiagBad(dpDiagBad), .diagRdData(diagRdData), .diagRdValid(diagRdValid),
    .diagRdLock(diagRdLock)
  );

  pxb_control #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctl (
    .clk(clk), .rstN(rstN), .lkEn(lkEn), .diagEn(diagEn), .diagIdx(diagIdx),
    .demapEn(demapEn), .statusClr(statusClr),
    .dpFound(dpFound), .dpIdx(dpIdx), .dpDataBad(dpDataBad), .dpDiagBad(dpDiagBad),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkErr(lkErr), .lkIdx(lkIdx), .strobe(strobe),
    .faultValid(faultValid), .faultIdx(faultIdx), .urgErr(urgErr), .urgIdx(urgIdx)
  );

  assign lkData = lkHit ? dpData : '0;
endmodule

// File: tb/parity_xlat_buf_bench.sv
`timescale 1ns/1ps
module parity_xlat_buf_bench;
  localparam int N  = 16;
  localparam int TW = 10;
  localparam int DW = 14;
  localparam int IW = 4;
  localparam int RW = 14;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rstN;
  logic wrEn, wrLock, wrFlipTagPar, wrFlipDataPar;
  logic [IW-1:0] wrIdx, diagIdx, demapIdx;
  logic [TW-1:0] wrTag, lkVpn;
  logic [DW-1:0] wrData;
  logic lkEn, diagEn, diagSelData, demapEn;
  logic [1:0] statusClr;
  logic lkHit, lkMiss, lkErr, diagRdValid, diagRdLock, faultValid, urgErr;
  logic [IW-1:0] lkIdx, faultIdx, urgIdx;
  logic [DW-1:0] lkData;
  logic [RW-1:0] diagRdData;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  parity_xlat_buf #(.NUM_ENTRIES(N), .TAG_W(TW), .DATA_W(DW)) u_parity_xlat_buf (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag), .wrData(wrData), .wrLock(wrLock),
    .wrFlipTagPar(wrFlipTagPar), .wrFlipDataPar(wrFlipDataPar),
    .lkEn(lkEn), .lkVpn(lkVpn), .lkHit(lkHit), .lkMiss(lkMiss), .lkErr(lkErr),
    .lkIdx(lkIdx), .lkData(lkData),
    .diagEn(diagEn), .diagIdx(diagIdx), .diagSelData(diagSelData),
    .diagRdData(diagRdData), .diagRdValid(diagRdValid), .diagRdLock(diagRdLock),
    .demapEn(demapEn), .demapIdx(demapIdx), .statusClr(statusClr),
    .faultValid(faultValid), .faultIdx(faultIdx), .urgErr(urgErr), .urgIdx(urgIdx)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drvIdle();
    wrEn = 0; wrIdx = '0; wrTag = '0; wrData = '0; wrLock = 0;
    wrFlipTagPar = 0; wrFlipDataPar = 0;
    lkEn = 0; lkVpn = '0; diagEn = 0; diagIdx = '0; diagSelData = 0;
    demapEn = 0; demapIdx = '0; statusClr = 2'b00;
  endtask

  task automatic cycWrite(input logic [IW-1:0] idx, input logic [TW-1:0] tag, input logic [DW-1:0] data,
                          input logic lock, input logic ft, input logic fd);
    @(negedge clk); drvIdle();
    wrEn = 1; wrIdx = idx; wrTag = tag; wrData = data; wrLock = lock;
    wrFlipTagPar = ft; wrFlipDataPar = fd;
  endtask

  task automatic cycLook(input string req, input logic [TW-1:0] vpn, input logic [1:0] clr,
                         input logic eh, input logic em, input logic ee,
                         input logic [IW-1:0] eIdx, input logic [DW-1:0] eData);
    @(negedge clk); drvIdle();
    lkEn = 1; lkVpn = vpn; statusClr = clr;
    #4;
    chk(req, "lkHit",  32'(lkHit),  32'(eh));
    chk(req, "lkMiss", 32'(lkMiss), 32'(em));
    chk(req, "lkErr",  32'(lkErr),  32'(ee));
    chk(req, "lkIdx",  32'(lkIdx),  32'(eIdx));
    chk(req, "lkData", 32'(lkData), 32'(eData));
  endtask

  task automatic cycDiag(input string req, input logic [IW-1:0] idx, input logic sel,
                         input logic [RW-1:0] eData, input logic eValid, input logic eLock);
    @(negedge clk); drvIdle();
    diagEn = 1; diagIdx = idx; diagSelData = sel;
    #4;
    chk(req, "diagRdData",  32'(diagRdData),  32'(eData));
    chk(req, "diagRdValid", 32'(diagRdValid), 32'(eValid));
    chk(req, "diagRdLock",  32'(diagRdLock),  32'(eLock));
  endtask

  task automatic cycStatus(input string req, input logic efv, input logic [IW-1:0] efi,
                           input logic eu, input logic [IW-1:0] eui);
    @(negedge clk); drvIdle();
    #4;
    chk(req, "faultValid", 32'(faultValid), 32'(efv));
    chk(req, "faultIdx",   32'(faultIdx),   32'(efi));
    chk(req, "urgErr",     32'(urgErr),     32'(eu));
    chk(req, "urgIdx",     32'(urgIdx),     32'(eui));
  endtask

  task automatic cycClear(input logic [1:0] bits);
    @(negedge clk); drvIdle(); statusClr = bits;
  endtask

  task automatic cycDemap(input logic [IW-1:0] idx);
    @(negedge clk); drvIdle(); demapEn = 1; demapIdx = idx;
  endtask

  // R10: reset state.
  task automatic tReset();
    cycStatus("R10", 0, 0, 0, 0);
    cycDiag("R10", 4'd0, 1'b0, '0, 0, 0);
    cycDiag("R10", 4'd15, 1'b1, '0, 0, 0);
    cycLook("R10", 10'h000, 2'b00, 0, 1, 0, 0, 0);
  endtask

  // R1, R5: write then hit; other tag misses; idle is quiet.
  task automatic tBasic();
    cycWrite(4'd3, 10'h155, 14'h2A5A, 0, 0, 0);
    cycLook("R1", 10'h155, 2'b00, 1, 0, 0, 4'd3, 14'h2A5A);
    cycLook("R5", 10'h154, 2'b00, 0, 1, 0, 0, 0);
    @(negedge clk); drvIdle(); lkVpn = 10'h155; #4;
    chk("R5", "idle hit",  32'(lkHit),  0);
    chk("R5", "idle miss", 32'(lkMiss), 0);
    chk("R5", "idle err",  32'(lkErr),  0);
  endtask

  // R8: lowest index wins; boundary slots 0 and 15.
  task automatic tPriority();
    cycWrite(4'd9, 10'h0F0, 14'h1111, 0, 0, 0);
    cycWrite(4'd5, 10'h0F0, 14'h2222, 0, 0, 0);
    cycLook("R8", 10'h0F0, 2'b00, 1, 0, 0, 4'd5, 14'h2222);
    cycWrite(4'd15, 10'h3FF, 14'h3FFF, 0, 0, 0);
    cycLook("R8", 10'h3FF, 2'b00, 1, 0, 0, 4'd15, 14'h3FFF);
    cycWrite(4'd0, 10'h000, 14'h0001, 0, 0, 0);
    cycLook("R1", 10'h000, 2'b00, 1, 0, 0, 4'd0, 14'h0001);
  endtask

  // R2, R3: locked slot with bad tag parity misses; no fault recorded.
  task automatic tTagErr();
    cycWrite(4'd7, 10'h0AA, 14'h0123, 1, 1, 0);
    cycLook("R3", 10'h0AA, 2'b00, 0, 1, 0, 0, 0);
    cycWrite(4'd8, 10'h0AB, 14'h0124, 0, 1, 0);
    cycLook("R2", 10'h0AB, 2'b00, 0, 1, 0, 0, 0);
    cycStatus("R2", 0, 0, 0, 0);
  endtask

  // R4, R5, R6, R8: data parity on selected slot only; fault status.
  task automatic tDataErr();
    cycWrite(4'd10, 10'h233, 14'h0777, 0, 0, 1);
    cycLook("R4", 10'h155, 2'b00, 1, 0, 0, 4'd3, 14'h2A5A);
    cycStatus("R4", 0, 0, 0, 0);
    cycLook("R5", 10'h233, 2'b00, 0, 0, 1, 4'd10, 0);
    cycStatus("R6", 1, 4'd10, 0, 0);
    cycLook("R6", 10'h155, 2'b00, 1, 0, 0, 4'd3, 14'h2A5A);
    cycStatus("R6", 1, 4'd10, 0, 0);
    cycClear(2'b10);
    cycStatus("R6", 1, 4'd10, 0, 0);
    cycClear(2'b01);
    cycStatus("R6", 0, 0, 0, 0);
    cycWrite(4'd1, 10'h2C2, 14'h0042, 0, 0, 1);
    cycWrite(4'd2, 10'h2C2, 14'h0043, 0, 0, 0);
    cycLook("R8", 10'h2C2, 2'b01, 0, 0, 1, 4'd1, 0);
    cycStatus("R6", 1, 4'd1, 0, 0);
    cycClear(2'b01);
    cycStatus("R6", 0, 0, 0, 0);
  endtask

  // R7: diagnostic reads, auto-invalidate, urgent flag.
  task automatic tDiag();
    cycDiag("R7", 4'd3, 1'b0, 14'h0155, 1, 0);
    cycDiag("R7", 4'd3, 1'b1, 14'h2A5A, 1, 0);
    cycStatus("R7", 0, 0, 0, 0);
    cycDiag("R7", 4'd10, 1'b1, 14'h0777, 1, 0);
    cycDiag("R7", 4'd10, 1'b0, 14'h0233, 0, 0);
    cycStatus("R7", 0, 0, 1, 4'd10);
    cycLook("R7", 10'h233, 2'b00, 0, 1, 0, 0, 0);
    cycDiag("R7", 4'd7, 1'b0, 14'h00AA, 1, 1);
    cycDiag("R7", 4'd7, 1'b1, 14'h0123, 0, 1);
    cycStatus("R7", 0, 0, 1, 4'd7);
    cycClear(2'b01);
    cycStatus("R7", 0, 0, 1, 4'd7);
    cycClear(2'b10);
    cycStatus("R7", 0, 0, 0, 0);
  endtask

  // R9: demap a locked slot.
  task automatic tDemap();
    cycWrite(4'd12, 10'h1C1, 14'h0C0C, 1, 0, 0);
    cycLook("R9", 10'h1C1, 2'b00, 1, 0, 0, 4'd12, 14'h0C0C);
    cycDemap(4'd12);
    cycLook("R9", 10'h1C1, 2'b00, 0, 1, 0, 0, 0);
    cycDiag("R9", 4'd12, 1'b0, 14'h01C1, 0, 1);
  endtask

  initial begin
    #(MAX_CYC * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog R1 to R10: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    drvIdle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    tReset();
    tBasic();
    tPriority();
    tTagErr();
    tDataErr();
    tDiag();
    tDemap();
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule